// File: doc/BRIEF.md
# Calendar-Scheduled FIFO Status Channel Generator

This block drives a 2-bit-per-cycle flow-control status stream for a packet interface that carries many logical ports. Each cycle it emits one symbol. A frame opens with the framing code `2'b11`. It then sends the live 2-bit FIFO status of each port listed in a programmable calendar, in calendar order. It closes with a 2-bit DIP-2 check code. A port number may appear in the calendar more than once, so a fast port is reported several times per frame. The far end decodes the stream with the same calendar.

Software writes calendar entries and a control word through a simple write port. The control word holds the frame length (1 to 256 entries), a force-training bit and a diagnostic error-injection request. While training is forced, the channel sends `2'b11` continuously instead of frames. An injection request corrupts the DIP-2 code of a programmed number of consecutive frames, and its busy flag then clears by itself. Calendar and length changes are staged and apply only when the next frame starts.

Top module: `fifo_stat_cal_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `stat_out` becomes `2'b11` and `err_busy` becomes 0. The calendar resets to all port 0, the length to 1 entry, and training is off.
- R2: Unless training is forced, a frame is exactly one `2'b11` framing cycle, then one cycle per used calendar entry, then one DIP-2 cycle. The next framing cycle follows immediately.
- R3: In the cycle for calendar index i (i counts from 0), `stat_out` is bits [2p+1:2p] of `port_status`, where p is the port number stored at index i. Repeated entries repeat the report.
- R4: With no injection pending, the DIP-2 code has bit k equal to the inverse of the XOR of bit k over all entry symbols of that frame (odd parity per lane, k = 0 and 1). The framing code is excluded.
- R5: A force-training control of 1 is acted on at a frame boundary. A frame already in progress completes first. From then on `stat_out` is `2'b11` on every cycle until the control is written back to 0, after which a new frame starts.
- R6: A control write with the start bit set loads the error count N and sets `err_busy`. The DIP-2 codes of the next N frames are sent with both bits inverted. `err_busy` drops in the same cycle that the N-th corrupted code appears.
- R7: A start with N = 0 corrupts no code. `err_busy` drops at the next DIP-2 cycle.
- R8: A calendar or length write never changes the frame in progress. The next frame uses every write accepted up to the clock edge that emits its framing code, excluding a write on that same edge.
- R9: A length field of L-1 gives L entries for every L from 1 to 256, including the full 256-entry calendar.
- R10: Each entry's status is sampled from `port_status` at the clock edge that emits it. It is not captured earlier in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_we | input | 1 | Calendar entry write strobe |
| cal_addr | input | 8 | Calendar index to write |
| cal_data | input | 8 | Port number stored at that index |
| ctl_we | input | 1 | Control word write strobe |
| ctl_force_train | input | 1 | 1 forces continuous training |
| ctl_len_m1 | input | 8 | Used calendar length minus one |
| ctl_err_count | input | 8 | Number of DIP-2 codes to corrupt |
| ctl_err_start | input | 1 | 1 with `ctl_we` starts error injection |
| port_status | input | 512 | 2-bit FIFO status per port, port p at [2p+1:2p] |
| stat_out | output | 2 | Status channel symbol |
| err_busy | output | 1 | Error injection still pending |

## Verification
`stat_out` is a register. A symbol computed from the inputs present at edge k is visible just after edge k, so an entry reflects the `port_status` value driven before that edge. A control write at edge E can first influence the force decision or the error counter at edge E+1. A calendar write at edge E reaches the frame whose framing code is sent at a later edge. The bench drives every input on the falling edge. At each rising edge its behavioural model takes the same inputs, produces the symbol and busy flag due at that edge, and then applies the writes. Both are compared against the ports on the following falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/fsc_pkg.sv
// Shared types and codes for the calendar-driven status channel generator.
// Assumes a 2-bit symbol channel on which 2'b11 serves as both framing and training.
package fsc_pkg;
    typedef enum logic [1:0] {
        ST_BOUND = 2'd0,
        ST_ENTRY = 2'd1,
        ST_DIP   = 2'd2
    } seq_st_t;

    localparam logic [1:0] FRAME_CODE = 2'b11;
    localparam logic [1:0] TRAIN_CODE = 2'b11;
endpackage

// File: rtl/fsc_cal_store.sv
// Calendar storage. The write port fills a staging copy at any time. A load
// pulse at a frame start copies the whole staging copy into the active copy,
// which the sequencer reads. Assumes load is only asserted at a frame boundary.
module fsc_cal_store #(
    parameter int CAL_DEPTH = 256,
    parameter int PORT_W    = 8,
    localparam int IDX_W    = $clog2(CAL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              load,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PORT_W-1:0] rd_port
);
    logic [CAL_DEPTH*PORT_W-1:0] act_flat;

    for (genvar g = 0; g < CAL_DEPTH; g++) begin : g_ent
        logic [PORT_W-1:0] stage_q;
        logic [PORT_W-1:0] act_q;

        // Staging entry takes software writes; active entry refreshes on a frame-start load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= '0;
                act_q   <= '0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(g)) stage_q <= wr_port;
                if (load) act_q <= stage_q;
            end
        end

        assign act_flat[g*PORT_W +: PORT_W] = act_q;
    end

    // Read port into the active copy.
    always_comb rd_port = act_flat[rd_idx*PORT_W +: PORT_W];

    // R8: the active calendar only moves on a frame-start load.
    p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_flat));
endmodule

// File: rtl/fsc_dip_gen.sv
// DIP-2 accumulator and diagnostic error injector. Accumulates the XOR of the
// frame's entry symbols and presents the odd-parity code. The code is inverted
// while injections remain. Assumes frame_start, entry_valid and dip_now are
// mutually exclusive.
module fsc_dip_gen #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             entry_valid,
    input  logic [1:0]       entry_stat,
    input  logic             dip_now,
    input  logic             ctl_we,
    input  logic             ctl_err_start,
    input  logic [ERR_W-1:0] ctl_err_count,
    output logic [1:0]       dip_code,
    output logic             err_busy
);
    logic [1:0]       acc_q;
    logic [ERR_W-1:0] left_q;
    logic             busy_q;
    logic             corrupt;

    // Parity lane accumulator, cleared at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)           acc_q <= 2'b00;
        else if (frame_start) acc_q <= 2'b00;
        else if (entry_valid) acc_q <= acc_q ^ entry_stat;
    end

    // Injection counter: a start write wins over a decrement on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (ctl_we && ctl_err_start) begin
            busy_q <= 1'b1;
            left_q <= ctl_err_count;
        end else if (dip_now && busy_q) begin
            if (left_q != '0) begin
                left_q <= left_q - 1'b1;
                if (left_q == ERR_W'(1)) busy_q <= 1'b0;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    // Odd-parity code, with both bits inverted when an injection is due.
    always_comb begin
        corrupt  = busy_q && (left_q != '0);
        dip_code = ~acc_q ^ {2{corrupt}};
        err_busy = busy_q;
    end

    // R6: each corrupted code consumes exactly one count.
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dip_now && busy_q && left_q != '0 && !(ctl_we && ctl_err_start)
        |=> left_q == $past(left_q) - 1'b1);

    // R6 and R7: the busy flag only drops on a DIP-2 cycle.
    p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(dip_now));
endmodule

// File: rtl/fsc_frame_seq.sv
// Frame sequencer. It holds the control word, walks framing, calendar entries
// and DIP-2, and registers the output symbol. At each boundary it either sends
// a training symbol or starts a frame with the staged length.
// Assumes the calendar store returns the entry for rd_idx combinationally.
module fsc_frame_seq
    import fsc_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int IDX_W     = 8,
    parameter int NUM_PORTS = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_we,
    input  logic                   ctl_force_train,
    input  logic [IDX_W-1:0]       ctl_len_m1,
    input  logic [PORT_W-1:0]      rd_port,
    input  logic [2*NUM_PORTS-1:0] port_status,
    input  logic [1:0]             dip_code,
    output logic                   load,
    output logic                   entry_valid,
    output logic [1:0]             entry_stat,
    output logic                   dip_now,
    output logic [IDX_W-1:0]       rd_idx,
    output logic [1:0]             stat_out
);
    seq_st_t          state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] alen_m1;
    logic [IDX_W-1:0] len_m1_q;
    logic             force_q;

    // Decode the current phase and select the listed port's live status.
    always_comb begin
        load        = (state == ST_BOUND) && !force_q;
        entry_valid = (state == ST_ENTRY);
        dip_now     = (state == ST_DIP);
        rd_idx      = idx;
        entry_stat  = port_status[{rd_port, 1'b0} +: 2];
    end

    // Control register, phase state and registered output symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_BOUND;
            idx      <= '0;
            alen_m1  <= '0;
            len_m1_q <= '0;
            force_q  <= 1'b0;
            stat_out <= TRAIN_CODE;
        end else begin
            if (ctl_we) begin
                force_q  <= ctl_force_train;
                len_m1_q <= ctl_len_m1;
            end
            unique case (state)
                ST_BOUND: begin
                    if (force_q) begin
                        stat_out <= TRAIN_CODE;
                    end else begin
                        stat_out <= FRAME_CODE;
                        alen_m1  <= len_m1_q;
                        idx      <= '0;
                        state    <= ST_ENTRY;
                    end
                end
                ST_ENTRY: begin
                    stat_out <= entry_stat;
                    if (idx == alen_m1) state <= ST_DIP;
                    else                idx   <= idx + 1'b1;
                end
                ST_DIP: begin
                    stat_out <= dip_code;
                    state    <= ST_BOUND;
                end
                default: state <= ST_BOUND;
            endcase
        end
    end

    // R5: a forced boundary emits training and stays at the boundary.
    p_train_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BOUND && force_q |=> stat_out == TRAIN_CODE && state == ST_BOUND);

    // R2: the last entry is followed by the DIP-2 cycle.
    p_last_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ENTRY && idx == alen_m1 |=> state == ST_DIP);

    // R2: DIP-2 is always followed by a boundary.
    p_dip_then_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DIP |=> state == ST_BOUND);

    // R9: the entry index stays inside the used length.
    p_idx_in_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ENTRY |-> idx <= alen_m1);
endmodule

// File: rtl/fifo_stat_cal_gen.sv
// Top level of the calendar-scheduled FIFO status channel generator.
// Connects the calendar store, the frame sequencer and the DIP-2 generator.
// Assumes one symbol per clock and port numbers covering every port of port_status.
module fifo_stat_cal_gen #(
    parameter int CAL_DEPTH  = 256,
    parameter int PORT_W     = 8,
    parameter int ERR_W      = 8,
    localparam int IDX_W     = $clog2(CAL_DEPTH),
    localparam int NUM_PORTS = 1 << PORT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cal_we,
    input  logic [IDX_W-1:0]       cal_addr,
    input  logic [PORT_W-1:0]      cal_data,
    input  logic                   ctl_we,
    input  logic                   ctl_force_train,
    input  logic [IDX_W-1:0]       ctl_len_m1,
    input  logic [ERR_W-1:0]       ctl_err_count,
    input  logic                   ctl_err_start,
    input  logic [2*NUM_PORTS-1:0] port_status,
    output logic [1:0]             stat_out,
    output logic                   err_busy
);
    logic              load;
    logic              entry_valid;
    logic              dip_now;
    logic [1:0]        entry_stat;
    logic [1:0]        dip_code;
    logic [IDX_W-1:0]  rd_idx;
    logic [PORT_W-1:0] rd_port;

    fsc_cal_store #(.CAL_DEPTH(CAL_DEPTH), .PORT_W(PORT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cal_we),
        .wr_idx  (cal_addr),
        .wr_port (cal_data),
        .load    (load),
        .rd_idx  (rd_idx),
        .rd_port (rd_port)
    );

    fsc_frame_seq #(.PORT_W(PORT_W), .IDX_W(IDX_W), .NUM_PORTS(NUM_PORTS)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctl_we          (ctl_we),
        .ctl_force_train (ctl_force_train),
        .ctl_len_m1      (ctl_len_m1),
        .rd_port         (rd_port),
        .port_status     (port_status),
        .dip_code        (dip_code),
        .load            (load),
        .entry_valid     (entry_valid),
        .entry_stat      (entry_stat),
        .dip_now         (dip_now),
        .rd_idx          (rd_idx),
        .stat_out        (stat_out)
    );

    fsc_dip_gen #(.ERR_W(ERR_W)) u_dip (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (load),
        .entry_valid   (entry_valid),
        .entry_stat    (entry_stat),
        .dip_now       (dip_now),
        .ctl_we        (ctl_we),
        .ctl_err_start (ctl_err_start),
        .ctl_err_count (ctl_err_count),
        .dip_code      (dip_code),
        .err_busy      (err_busy)
    );
endmodule

// File: tb/fifo_stat_cal_gen_bench.sv
// Bench: a behavioural model of the status channel, stepped at every rising
// edge and compared with the outputs on the following falling edge.
module fifo_stat_cal_gen_bench;
    localparam int NP = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cal_we = 1'b0;
    logic [7:0]   cal_addr = '0;
    logic [7:0]   cal_data = '0;
    logic         ctl_we = 1'b0;
    logic         ctl_force_train = 1'b0;
    logic [7:0]   ctl_len_m1 = '0;
    logic [7:0]   ctl_err_count = '0;
    logic         ctl_err_start = 1'b0;
    logic [2*NP-1:0] port_status = '0;
    logic [1:0]   stat_out;
    logic         err_busy;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    string scen = "R1";

    fifo_stat_cal_gen u_fifo_stat_cal_gen (
        .clk(clk), .rst_n(rst_n), .cal_we(cal_we), .cal_addr(cal_addr),
        .cal_data(cal_data), .ctl_we(ctl_we), .ctl_force_train(ctl_force_train),
        .ctl_len_m1(ctl_len_m1), .ctl_err_count(ctl_err_count),
        .ctl_err_start(ctl_err_start), .port_status(port_status),
        .stat_out(stat_out), .err_busy(err_busy)
    );

    always #10 clk = ~clk;

    // Model state
    int    sh [NP];
    int    snap [$];
    int    m_state = 0;   // 0 boundary, 1 entries, 2 check code
    int    m_pos = 0;
    int    m_len = 1;
    int    m_force = 0;
    int    m_cnt = 0;
    int    m_busy = 0;
    int    m_acc = 0;
    int    m_out = 3;
    string m_tag = "R1";
    bit    started = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [scenario %s] at cycle %0d: actual %0d expected %0d", req, scen, cyc, act, exp);
        end
    endtask

    // Reference model: one step per rising edge, writes applied after the step.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            foreach (sh[i]) sh[i] = 0;
            m_state = 0; m_len = 1; m_force = 0; m_cnt = 0; m_busy = 0;
            m_acc = 0; m_out = 3; m_tag = "R1";
        end else begin
            case (m_state)
                0: begin
                    m_out = 3;
                    if (m_force != 0) m_tag = "R5";
                    else begin
                        m_tag = "R2";
                        snap = {};
                        for (int i = 0; i < m_len; i++) snap.push_back(sh[i]);
                        m_pos = 0; m_acc = 0; m_state = 1;
                    end
                end
                1: begin
                    m_out = int'(port_status[2*snap[m_pos] +: 2]);
                    m_acc = m_acc ^ m_out;
                    m_tag = "R3";
                    m_pos++;
                    if (m_pos == snap.size()) m_state = 2;
                end
                default: begin
                    m_out = (~m_acc) & 3;
                    m_tag = "R4";
                    if (m_busy != 0) begin
                        if (m_cnt != 0) begin
                            m_out = m_out ^ 3; m_cnt--; m_tag = "R6";
                            if (m_cnt == 0) m_busy = 0;
                        end else begin
                            m_busy = 0; m_tag = "R7";
                        end
                    end
                    m_state = 0;
                end
            endcase
            if (cal_we) sh[cal_addr] = int'(cal_data);
            if (ctl_we) begin
                m_force = int'(ctl_force_train);
                m_len = int'(ctl_len_m1) + 1;
                if (ctl_err_start) begin m_busy = 1; m_cnt = int'(ctl_err_count); end
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk(m_tag, int'(stat_out), m_out);
            chk("R6", int'(err_busy), m_busy);
        end
    end

    // Watchdog ends a hung run as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic cal_write(input int idx, input int port);
        @(negedge clk);
        cal_we = 1'b1; cal_addr = 8'(idx); cal_data = 8'(port);
        @(negedge clk);
        cal_we = 1'b0;
    endtask

    task automatic ctl_write(input bit frc, input int len_m1, input int errn, input bit start);
        @(negedge clk);
        ctl_we = 1'b1; ctl_force_train = frc; ctl_len_m1 = 8'(len_m1);
        ctl_err_count = 8'(errn); ctl_err_start = start;
        @(negedge clk);
        ctl_we = 1'b0; ctl_err_start = 1'b0;
    endtask

    task automatic rand_status();
        for (int i = 0; i < 2*NP; i += 32) port_status[i +: 32] = $urandom;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        scen = "R1";
        run(3);
        chk("R1", int'(stat_out), 3);
        chk("R1", int'(err_busy), 0);
        rst_n = 1'b1;

        // R3: repeated ports in a 4-entry calendar, steady status
        scen = "R3";
        rand_status();
        cal_write(0, 5); cal_write(1, 9); cal_write(2, 5); cal_write(3, 200);
        ctl_write(0, 3, 0, 0);
        run(30);

        // R10: status changes every cycle
        scen = "R10";
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            rand_status();
        end

        // R8: calendar and length writes land mid-frame
        scen = "R8";
        for (int k = 0; k < 20; k++) begin
            cal_write(int'($urandom_range(0, 5)), int'($urandom_range(0, 255)));
            ctl_write(0, int'($urandom_range(0, 5)), 0, 0);
            run(int'($urandom_range(0, 3)));
        end
        ctl_write(0, 3, 0, 0);
        run(12);

        // R5: forced training, then release
        scen = "R5";
        ctl_write(1, 3, 0, 0);
        run(25);
        chk("R5", int'(stat_out), 3);
        ctl_write(0, 3, 0, 0);
        run(20);

        // R6: three corrupted check codes, then busy clears
        scen = "R6";
        ctl_write(0, 1, 3, 1);
        run(40);
        chk("R6", int'(err_busy), 0);

        // R7: a start with zero count corrupts nothing
        scen = "R7";
        ctl_write(0, 1, 0, 1);
        run(10);
        chk("R7", int'(err_busy), 0);

        // R9: full 256-entry calendar
        scen = "R9";
        for (int i = 0; i < 256; i++) cal_write(i, 255 - i);
        ctl_write(0, 255, 0, 0);
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            rand_status();
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule